// File: doc/BRIEF.md
# Indirect SDRAM Controller Register File

This block is the configuration register file of a DDR memory controller. It sits on a device-control bus and answers two bus indices. One is an offset port and the other is a data port. Software first writes an internal register offset into the offset port. It then reads or writes the data port, and that access reaches the register the offset selects. The block holds these registers: two error status words, an error address, a global configuration word, a read-only status word, refresh, power-management and ECC configuration words, an ECC error status word, and one configuration word per memory bank.

Each register applies its own write mask. The error status words are write-one-to-clear. Bit 31 of the configuration word is a global enable. Its edges map or unmap every populated bank, and the status word reflects its state in inverted form. Each bank's configuration word is decoded into a base address and a size. Those, together with a mapped flag, drive the memory decoder. An interrupt line follows whether the ECC error status is nonzero.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A read of the offset port (bus index ADDR_PORT, default 0x10) returns the last 32-bit value written to it. The value after reset is 0.
- R2: After reset, the data port reads the following: configuration (offset 0x20) 0x00800000, power management (0x34) 0x07C00000, refresh (0x30) 0x05F00000. Every other stored register reads 0, ecc_irq is low and no bank is mapped.
- R3: Each write is stored ANDed with a per-register mask:
  - configuration: 0xFFE00000
  - refresh: 0x3FF80000
  - ECC configuration (0x94): 0x00F00000
  - ECC error status (0x98): 0xFFF0F000
  - bank words (0x40, 0x44, 0x48, 0x4C for banks 0 to 3): 0xFFDEE001
  - power management: the write ANDed with 0xF8000000 and then ORed with 0x07C00000
  - error address (0x10): stored unmasked
- R4: A data-port read at the timing offset 0x80 returns 0xFFFFFFFF, and so does a read at any offset the block does not define. A read at a bus index that is neither port returns 0.
- R5: A write to error status 0 (0x00) or error status 1 (0x08) clears each bit that is one in the written value and never sets a bit.
- R6: When a configuration write takes bit 31 from 0 to 1, status (0x24) bit 31 clears and the populated banks become eligible for mapping. When a write takes bit 31 from 1 to 0, status bit 31 sets and no bank stays mapped.
- R7: When a configuration write takes bit 30 from 0 to 1, status bit 30 sets. When a write takes bit 30 from 1 to 0, status bit 30 clears. Writes to the status offset change nothing.
- R8: For bank i, bank_base equals the bank word ANDed with 0xFF800000. bank_size equals 0x00400000 shifted left by bits [19:17] of the word. Code 7 gives a size of 0 and the bank is never mapped.
- R9: bank_mapped[i] is 1 only when four conditions hold: bank i is populated (POP_MASK bit i), bit 0 of its word is 1, configuration bit 31 is 1 and the size code is not 7.
- R10: A write to the word of a bank whose POP_MASK bit is 0 is ignored. The word keeps reading 0 and the bank is never mapped.
- R11: ecc_irq goes high after a write that leaves the ECC error status nonzero. It goes low after a write that leaves it zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the release is synchronised inside the block |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | IDX_W | Bus register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational, valid while bus_sel is high and bus_we is low |
| bank_mapped | output | NBANKS | Per-bank mapped flag |
| bank_base | output | 32*NBANKS | Decoded base address per bank; bank i in bits [32*i+31:32*i] |
| bank_size | output | 32*NBANKS | Decoded size in bytes per bank; 0 for an invalid code |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
Every write takes effect at the clock edge that samples it. Registers, status bits, ecc_irq, bank_mapped, bank_base and bank_size therefore all hold their new values from that edge onward. Reads are combinational, so read data is valid in the same cycle the read is presented. The bench drives each access on a falling edge and lets one rising edge pass for a write. It then samples reads and side outputs a little after the next falling edge, so no check races the edge that made the change. After reset, the internal reset synchroniser takes two edges to release, and the bench waits several cycles before its first check.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int DATA_W = 32;

  localparam logic [DATA_W-1:0] OFS_ERRST0 = 32'h00;
  localparam logic [DATA_W-1:0] OFS_ERRST1 = 32'h08;
  localparam logic [DATA_W-1:0] OFS_ERRADR = 32'h10;
  localparam logic [DATA_W-1:0] OFS_CFG    = 32'h20;
  localparam logic [DATA_W-1:0] OFS_STAT   = 32'h24;
  localparam logic [DATA_W-1:0] OFS_RFSH   = 32'h30;
  localparam logic [DATA_W-1:0] OFS_PWR    = 32'h34;
  localparam logic [DATA_W-1:0] OFS_BANK0  = 32'h40;
  localparam logic [DATA_W-1:0] OFS_TIMING = 32'h80;
  localparam logic [DATA_W-1:0] OFS_ECCCF  = 32'h94;
  localparam logic [DATA_W-1:0] OFS_ECCST  = 32'h98;

  localparam logic [DATA_W-1:0] MSK_CFG   = 32'hFFE0_0000;
  localparam logic [DATA_W-1:0] MSK_RFSH  = 32'h3FF8_0000;
  localparam logic [DATA_W-1:0] MSK_PWR   = 32'hF800_0000;
  localparam logic [DATA_W-1:0] SET_PWR   = 32'h07C0_0000;
  localparam logic [DATA_W-1:0] MSK_ECCCF = 32'h00F0_0000;
  localparam logic [DATA_W-1:0] MSK_ECCST = 32'hFFF0_F000;
  localparam logic [DATA_W-1:0] MSK_BANK  = 32'hFFDE_E001;
  localparam logic [DATA_W-1:0] MSK_BASE  = 32'hFF80_0000;

  localparam logic [DATA_W-1:0] RST_CFG  = 32'h0080_0000;
  localparam logic [DATA_W-1:0] RST_RFSH = 32'h05F0_0000;
  localparam logic [DATA_W-1:0] RST_PWR  = 32'h07C0_0000;

  localparam logic [DATA_W-1:0] MIN_BANK_SIZE = 32'h0040_0000;
  localparam logic [DATA_W-1:0] ALL_ONES      = 32'hFFFF_FFFF;
endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot
  import sdram_cfg_pkg::*;
#(
  parameter bit POPULATED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              gbl_en,
  output logic [DATA_W-1:0] word,
  output logic              mapped,
  output logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] size
);
  logic [DATA_W-1:0] word_q, word_d;
  logic              word_en;
  logic [2:0]        code;

  assign word_en = wr_en & POPULATED;
  assign word_d  = wdata & MSK_BANK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign code   = word_q[19:17];
  assign word   = word_q;
  assign base   = word_q & MSK_BASE;
  assign size   = (code == 3'd7) ? '0 : (MIN_BANK_SIZE << code);
  assign mapped = POPULATED & word_q[0] & gbl_en & (code != 3'd7);
endmodule

// File: rtl/sdram_cfg_core.sv
module sdram_cfg_core
  import sdram_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] errst0,
  output logic [DATA_W-1:0] errst1,
  output logic [DATA_W-1:0] erradr,
  output logic [DATA_W-1:0] cfg,
  output logic [DATA_W-1:0] stat,
  output logic [DATA_W-1:0] rfsh,
  output logic [DATA_W-1:0] pwr,
  output logic [DATA_W-1:0] ecccf,
  output logic [DATA_W-1:0] eccst,
  output logic              irq
);
  logic [DATA_W-1:0] errst0_d, errst1_d, cfg_d, stat_d, pwr_d, ecccf_d, eccst_d, rfsh_d;
  logic              en_e0, en_e1, en_ea, en_cfg, en_rf, en_pw, en_ec, en_es;
  logic [DATA_W-1:0] cfg_new;

  assign en_e0  = wr_en && (wr_off == OFS_ERRST0);
  assign en_e1  = wr_en && (wr_off == OFS_ERRST1);
  assign en_ea  = wr_en && (wr_off == OFS_ERRADR);
  assign en_cfg = wr_en && (wr_off == OFS_CFG);
  assign en_rf  = wr_en && (wr_off == OFS_RFSH);
  assign en_pw  = wr_en && (wr_off == OFS_PWR);
  assign en_ec  = wr_en && (wr_off == OFS_ECCCF);
  assign en_es  = wr_en && (wr_off == OFS_ECCST);

  assign cfg_new = wdata & MSK_CFG;

  always_comb begin
    errst0_d = errst0 & ~wdata;
    errst1_d = errst1 & ~wdata;
    cfg_d    = cfg_new;
    rfsh_d   = wdata & MSK_RFSH;
    pwr_d    = (wdata & MSK_PWR) | SET_PWR;
    ecccf_d  = wdata & MSK_ECCCF;
    eccst_d  = wdata & MSK_ECCST;
    stat_d   = stat;
    if (!cfg[31] && cfg_new[31])      stat_d[31] = 1'b0;
    else if (cfg[31] && !cfg_new[31]) stat_d[31] = 1'b1;
    if (!cfg[30] && cfg_new[30])      stat_d[30] = 1'b1;
    else if (cfg[30] && !cfg_new[30]) stat_d[30] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errst0 <= '0;
      errst1 <= '0;
      erradr <= '0;
      cfg    <= RST_CFG;
      stat   <= '0;
      rfsh   <= RST_RFSH;
      pwr    <= RST_PWR;
      ecccf  <= '0;
      eccst  <= '0;
      irq    <= 1'b0;
    end else begin
      if (en_e0)  errst0 <= errst0_d;
      if (en_e1)  errst1 <= errst1_d;
      if (en_ea)  erradr <= wdata;
      if (en_cfg) begin
        cfg  <= cfg_d;
        stat <= stat_d;
      end
      if (en_rf)  rfsh  <= rfsh_d;
      if (en_pw)  pwr   <= pwr_d;
      if (en_ec)  ecccf <= ecccf_d;
      if (en_es) begin
        eccst <= eccst_d;
        irq   <= |eccst_d;
      end
    end
  end
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int                 NBANKS    = 4,
  parameter logic [NBANKS-1:0]  POP_MASK  = 4'b0111,
  parameter int                 IDX_W     = 10,
  parameter logic [IDX_W-1:0]   ADDR_PORT = 10'h010,
  parameter logic [IDX_W-1:0]   DATA_PORT = 10'h011
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_we,
  input  logic [IDX_W-1:0]         bus_idx,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [NBANKS-1:0]        bank_mapped,
  output logic [DATA_W*NBANKS-1:0] bank_base,
  output logic [DATA_W*NBANKS-1:0] bank_size,
  output logic                     ecc_irq
);
  logic              rst_sn;
  logic [DATA_W-1:0] addr_q;
  logic              addr_wr, data_wr;
  logic [DATA_W-1:0] errst0, errst1, erradr, cfg_q, stat_q, rfsh, pwr, ecccf, eccst;
  logic [DATA_W-1:0] bank_word [NBANKS];
  logic [DATA_W-1:0] data_rd;

  sdram_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign addr_wr = bus_sel && bus_we && (bus_idx == ADDR_PORT);
  assign data_wr = bus_sel && bus_we && (bus_idx == DATA_PORT);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      addr_q <= '0;
    else if (addr_wr) addr_q <= bus_wdata;
  end

  sdram_cfg_core u_core (
    .clk(clk), .rst_n(rst_sn), .wr_en(data_wr), .wr_off(addr_q), .wdata(bus_wdata),
    .errst0(errst0), .errst1(errst1), .erradr(erradr), .cfg(cfg_q), .stat(stat_q),
    .rfsh(rfsh), .pwr(pwr), .ecccf(ecccf), .eccst(eccst), .irq(ecc_irq)
  );

  for (genvar i = 0; i < NBANKS; i++) begin : g_bank
    localparam logic [DATA_W-1:0] BANK_OFS = OFS_BANK0 + DATA_W'(4 * i);
    sdram_bank_slot #(.POPULATED(POP_MASK[i])) u_slot (
      .clk(clk), .rst_n(rst_sn),
      .wr_en(data_wr && (addr_q == BANK_OFS)),
      .wdata(bus_wdata), .gbl_en(cfg_q[31]),
      .word(bank_word[i]), .mapped(bank_mapped[i]),
      .base(bank_base[DATA_W*i +: DATA_W]), .size(bank_size[DATA_W*i +: DATA_W])
    );
  end

  always_comb begin
    data_rd = ALL_ONES;
    case (addr_q)
      OFS_ERRST0: data_rd = errst0;
      OFS_ERRST1: data_rd = errst1;
      OFS_ERRADR: data_rd = erradr;
      OFS_CFG:    data_rd = cfg_q;
      OFS_STAT:   data_rd = stat_q;
      OFS_RFSH:   data_rd = rfsh;
      OFS_PWR:    data_rd = pwr;
      OFS_ECCCF:  data_rd = ecccf;
      OFS_ECCST:  data_rd = eccst;
      default:    data_rd = ALL_ONES;
    endcase
    for (int i = 0; i < NBANKS; i++) begin
      if (addr_q == OFS_BANK0 + DATA_W'(4 * i)) data_rd = bank_word[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (bus_idx == ADDR_PORT)      bus_rdata = addr_q;
      else if (bus_idx == DATA_PORT) bus_rdata = data_rd;
    end
  end
endmodule

// File: rtl/sdram_cfg_chk.sv
module sdram_cfg_chk
  import sdram_cfg_pkg::*;
#(
  parameter int                NBANKS    = 4,
  parameter logic [NBANKS-1:0] POP_MASK  = 4'b0111,
  parameter int                IDX_W     = 10,
  parameter logic [IDX_W-1:0]  ADDR_PORT = 10'h010,
  parameter logic [IDX_W-1:0]  DATA_PORT = 10'h011
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [IDX_W-1:0]  bus_idx,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] addr_q,
  input logic [DATA_W-1:0] cfg_q,
  input logic [DATA_W-1:0] stat_q,
  input logic [NBANKS-1:0] bank_mapped,
  input logic              ecc_irq
);
  logic aw, dw;
  assign aw = bus_sel && bus_we && (bus_idx == ADDR_PORT);
  assign dw = bus_sel && bus_we && (bus_idx == DATA_PORT);

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    aw |=> (addr_q == $past(bus_wdata))); // R1

  AST_EN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (dw && addr_q == OFS_CFG && bus_wdata[31] && !cfg_q[31]) |=> (cfg_q[31] && !stat_q[31])); // R6

  AST_EN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (dw && addr_q == OFS_CFG && !bus_wdata[31] && cfg_q[31]) |=> (stat_q[31] && bank_mapped == '0)); // R6

  AST_STAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (dw && addr_q == OFS_STAT) |=> $stable(stat_q)); // R7

  AST_MAP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_mapped != '0) |-> cfg_q[31]); // R9

  AST_UNPOP_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_mapped & ~POP_MASK) == '0)); // R10

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (dw && addr_q == OFS_ECCST && ((bus_wdata & MSK_ECCST) != '0)) |=> ecc_irq); // R11

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (dw && addr_q == OFS_ECCST && ((bus_wdata & MSK_ECCST) == '0)) |=> !ecc_irq); // R11
endmodule

bind sdram_cfg_regs sdram_cfg_chk #(
  .NBANKS(NBANKS), .POP_MASK(POP_MASK), .IDX_W(IDX_W),
  .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_sn), .bus_sel(bus_sel), .bus_we(bus_we), .bus_idx(bus_idx),
  .bus_wdata(bus_wdata), .addr_q(addr_q), .cfg_q(cfg_q), .stat_q(stat_q),
  .bank_mapped(bank_mapped), .ecc_irq(ecc_irq)
);

// File: tb/tb_sdram_cfg_regs.sv
module tb_sdram_cfg_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [9:0]  bus_idx;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  bank_mapped;
  logic [127:0] bank_base, bank_size;
  logic        ecc_irq;

  int n_run = 0, n_fail = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  sdram_cfg_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bank_mapped(bank_mapped),
    .bank_base(bank_base), .bank_size(bank_size), .ecc_irq(ecc_irq)
  );

  // {offset, write value, expected read}
  localparam logic [95:0] VEC [13] = '{
    {32'h30, 32'hFFFF_FFFF, 32'h3FF8_0000},  // R3 refresh
    {32'h34, 32'hFFFF_FFFF, 32'hFFC0_0000},  // R3 power
    {32'h34, 32'h0000_0000, 32'h07C0_0000},  // R3 power
    {32'h94, 32'hFFFF_FFFF, 32'h00F0_0000},  // R3 ecc cfg
    {32'h10, 32'h1234_5678, 32'h1234_5678},  // R3 err addr
    {32'h80, 32'h0000_0000, 32'hFFFF_FFFF},  // R4 timing
    {32'h5C, 32'h0000_0000, 32'hFFFF_FFFF},  // R4 unknown
    {32'h00, 32'hFFFF_FFFF, 32'h0000_0000},  // R5
    {32'h08, 32'hFFFF_FFFF, 32'h0000_0000},  // R5
    {32'h40, 32'hFFFF_FFFF, 32'hFFDE_E001},  // R3 bank
    {32'h40, 32'h0000_0000, 32'h0000_0000},  // R3 bank
    {32'h24, 32'hFFFF_FFFF, 32'h0000_0000},  // R7 status ro
    {32'h4C, 32'hFFFF_FFFF, 32'h0000_0000}   // R10
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bwr(logic [9:0] idx, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_idx = idx; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    #1;
  endtask

  task automatic brd(logic [9:0] idx, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_idx = idx;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic reg_wr(logic [31:0] ofs, logic [31:0] d);
    bwr(10'h010, ofs);
    bwr(10'h011, d);
  endtask

  task automatic reg_rd(logic [31:0] ofs, output logic [31:0] d);
    bwr(10'h010, ofs);
    brd(10'h011, d);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bus_sel = 0; bus_we = 0; bus_idx = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    brd(10'h010, rv);            chk("R1 reset addr", rv, 32'h0);
    reg_rd(32'h20, rv);          chk("R2 cfg", rv, 32'h0080_0000);
    reg_rd(32'h34, rv);          chk("R2 pwr", rv, 32'h07C0_0000);
    reg_rd(32'h30, rv);          chk("R2 rfsh", rv, 32'h05F0_0000);
    reg_rd(32'h24, rv);          chk("R2 stat", rv, 32'h0);
    reg_rd(32'h98, rv);          chk("R2 eccst", rv, 32'h0);
    chk("R2 irq", {31'b0, ecc_irq}, 32'h0);
    chk("R2 mapped", {28'b0, bank_mapped}, 32'h0);

    for (int k = 0; k < 13; k++) begin
      reg_wr(VEC[k][95:64], VEC[k][63:32]);
      reg_rd(VEC[k][95:64], rv);
      chk("R3/R4/R5/R7/R10 table", rv, VEC[k][31:0]);
    end

    bwr(10'h010, 32'h98);
    brd(10'h010, rv);            chk("R1 readback", rv, 32'h98);
    brd(10'h012, rv);            chk("R4 other index", rv, 32'h0);

    reg_wr(32'h44, 32'h1006_0001);
    chk("R8 base1", bank_base[63:32], 32'h1000_0000);
    chk("R8 size1", bank_size[63:32], 32'h0200_0000);
    chk("R9 disabled", {28'b0, bank_mapped}, 32'h0);

    reg_wr(32'h20, 32'hC000_0000);
    reg_rd(32'h24, rv);          chk("R6/R7 stat on", rv, 32'h4000_0000);
    chk("R6 mapped", {28'b0, bank_mapped}, 32'h2);

    reg_wr(32'h48, 32'h000E_0001);
    chk("R8 code7 size", bank_size[95:64], 32'h0);
    chk("R8 code7 unmapped", {28'b0, bank_mapped}, 32'h2);

    reg_wr(32'h40, 32'h00C0_0001);
    chk("R8 base0", bank_base[31:0], 32'h0080_0000);
    chk("R8 size0", bank_size[31:0], 32'h0040_0000);
    chk("R9 mapped01", {28'b0, bank_mapped}, 32'h3);

    reg_wr(32'h4C, 32'h0000_0001);
    chk("R10 unpop map", {28'b0, bank_mapped}, 32'h3);
    reg_rd(32'h4C, rv);          chk("R10 unpop word", rv, 32'h0);

    reg_wr(32'h20, 32'h0000_0000);
    reg_rd(32'h24, rv);          chk("R6/R7 stat off", rv, 32'h8000_0000);
    chk("R6 unmapped", {28'b0, bank_mapped}, 32'h0);

    reg_wr(32'h20, 32'h001F_FFFF);
    reg_rd(32'h20, rv);          chk("R3 cfg mask", rv, 32'h0);
    reg_rd(32'h24, rv);          chk("R7 stat kept", rv, 32'h8000_0000);

    reg_wr(32'h20, 32'h8000_0000);
    reg_rd(32'h24, rv);          chk("R6 stat re-en", rv, 32'h0);
    chk("R6 remapped", {28'b0, bank_mapped}, 32'h3);

    reg_wr(32'h98, 32'h0000_F000);
    chk("R11 irq up", {31'b0, ecc_irq}, 32'h1);
    reg_rd(32'h98, rv);          chk("R3 eccst", rv, 32'h0000_F000);
    reg_wr(32'h98, 32'h000F_0FFF);
    chk("R11 irq masked down", {31'b0, ecc_irq}, 32'h0);
    reg_wr(32'h98, 32'hFFFF_FFFF);
    reg_rd(32'h98, rv);          chk("R3 eccst mask", rv, 32'hFFF0_F000);
    chk("R11 irq up2", {31'b0, ecc_irq}, 32'h1);
    reg_wr(32'h98, 32'h0);
    chk("R11 irq down", {31'b0, ecc_irq}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule